// File: doc/BRIEF.md
# Up-Counting Timer Channel with Compare Clear

This block is one up-counting timer channel with a counter of `CNT_W` bits (16 by default). It counts one step on each cycle where the `tick` clock-enable input is high and the run bit is set. A 3-bit clear-select field picks the counting mode. In free-running mode the counter wraps from all-ones to zero. In periodic mode it returns to zero when it matches a period register.

Two sticky status flags record events. The overflow flag records a wrap. The match flag records that the counter equalled the period register. Software reaches the block through a small register port with a write strobe, a read strobe and a combinational read-data path. To clear a flag, software reads it as 1 and then writes 0 to it.

Register map (word addresses on `reg_addr`):
- Address 0 is the control register. Bit 0 is the run bit, and bits [3:1] are the clear-select field.
- Address 1 is the counter.
- Address 2 is the period register.
- Address 3 is the status register. Bit 0 is the overflow flag, and bit 1 is the match flag.

Top module: `tmr_channel`

## Requirements
- R1: After reset, the control register reads 0 (stopped, clear-select 3'b000), the counter reads 0x0000, the period register reads 0xFFFF, and status reads 0.
- R2: The counter advances by exactly one on each clock where `tick` is 1 and the run bit is 1. It does not change on a clock where `tick` is 0.
- R3: Clearing the run bit holds the counter value even while `tick` pulses. Setting the run bit again resumes counting from the held value.
- R4: On a counting step from 0xFFFF the counter becomes 0x0000 and status bit 0 (overflow) is set. Counting then continues upward from 0x0000.
- R5: With clear-select 3'b001, a counting step taken while the counter equals the period register loads 0x0000 instead of incrementing, so one period lasts (period+1) ticks. That step also sets status bit 1 (match).
- R6: With any clear-select code other than 3'b001, the counter runs free past the period value without clearing. Status bit 1 is still set on a counting step taken at a match.
- R7: A status flag clears only when 0 is written to its bit after a status read that returned it as 1. Writing 0 without such a read, or writing 1, leaves the flag set.
- R8: If a flag's set event and a valid clear write fall on the same clock, the flag stays set.
- R9: With clear-select 3'b001 and period 0xFFFF, the step from 0xFFFF sets both status bits on the same clock and leaves the counter at 0x0000.
- R10: A write to the counter on a counting clock loads the written value. That write overrides both the increment and the compare clear, and no status event is raised on that clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Count clock-enable (prescaled rate) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (marks a status read) |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| ovf_flag | output | 1 | Overflow status flag |
| match_flag | output | 1 | Compare-match status flag |

## Verification
The assertions assume that `tick`, `reg_wr` and `reg_rd` are synchronous to `clk` and are never unknown once reset is released. They also assume that a status flag is only cleared through the read-then-write-zero sequence. The stimulus changes every input on the falling edge. It asserts at most one register strobe per clock, and it combines `tick` with a register write only in the directed priority cases. Every status clear in the bench is preceded by a status read, except in the one case that checks an unarmed clear has no effect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned NFLAG  = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 2'd0,
    A_COUNT  = 2'd1,
    A_PERIOD = 2'd2,
    A_STATUS = 2'd3
  } reg_addr_e;

  localparam logic [SEL_W-1:0] SEL_FREE  = 3'b000;
  localparam logic [SEL_W-1:0] SEL_MATCH = 3'b001;

  localparam int unsigned F_OVF   = 0;
  localparam int unsigned F_MATCH = 1;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         clr_on_match,
  input  logic [W-1:0] period,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic         ovf_evt,
  output logic         match_evt
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] count_d;
  logic         step;
  logic         hit;

  assign step = run && tick && !wr_cnt;
  assign hit  = (count == period);

  always_comb begin
    count_d   = count;
    ovf_evt   = 1'b0;
    match_evt = 1'b0;
    if (wr_cnt) begin
      count_d = wr_data;
    end else if (step) begin
      match_evt = hit;
      ovf_evt   = (count == CNT_MAX);
      if (clr_on_match && hit) count_d = '0;
      else                     count_d = count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

  // R3: stopped channel holds its count
  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> (count == $past(count)));

  // R2: no tick means no change
  p_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(count));

  // R4: wrap from all-ones lands on zero
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !wr_cnt && count == CNT_MAX) |=> (count == '0));

  // R5: compare clear in periodic mode
  p_match_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !wr_cnt && clr_on_match && count == period) |=> (count == '0));

  // R10: software write wins
  p_write_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (count == $past(wr_data)));
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic sts_rd,
  input  logic sts_wr,
  input  logic wr_bit,
  output logic flag
);
  logic armed, armed_d, flag_d, clr_req;

  assign clr_req = sts_wr && !wr_bit && armed;

  always_comb begin
    flag_d  = flag;
    armed_d = armed;
    if (sts_rd && flag) armed_d = 1'b1;
    if (clr_req) begin
      flag_d  = 1'b0;
      armed_d = 1'b0;
    end
    if (set_evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      flag  <= flag_d;
      armed <= armed_d;
    end
  end

  // R8: a set event always leaves the flag set
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);

  // R7: without a status write the flag cannot fall
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !sts_wr) |=> flag);

  // R7: writing a one never clears
  p_one_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && sts_wr && wr_bit) |=> flag);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              ovf_flag,
  output logic              match_flag
);
  localparam int unsigned CTRL_W = SEL_W + 1;

  logic [1:0]       rst_sync;
  logic             rst_n_i;
  logic             run_q, run_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] count;
  logic             ovf_evt, match_evt;
  logic             wr_ctrl, wr_cnt, wr_per, wr_sts, rd_sts;
  logic [NFLAG-1:0] set_vec, flags;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_cnt  = reg_wr && (reg_addr == A_COUNT);
  assign wr_per  = reg_wr && (reg_addr == A_PERIOD);
  assign wr_sts  = reg_wr && (reg_addr == A_STATUS);
  assign rd_sts  = reg_rd && (reg_addr == A_STATUS);

  always_comb begin
    run_d = run_q;
    sel_d = sel_q;
    per_d = per_q;
    if (wr_ctrl) begin
      run_d = reg_wdata[0];
      sel_d = reg_wdata[CTRL_W-1:1];
    end
    if (wr_per) per_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      run_q <= 1'b0;
      sel_q <= SEL_FREE;
      per_q <= {CNT_W{1'b1}};
    end else begin
      run_q <= run_d;
      sel_q <= sel_d;
      per_q <= per_d;
    end
  end

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .tick         (tick),
    .run          (run_q),
    .clr_on_match (sel_q == SEL_MATCH),
    .period       (per_q),
    .wr_cnt       (wr_cnt),
    .wr_data      (reg_wdata),
    .count        (count),
    .ovf_evt      (ovf_evt),
    .match_evt    (match_evt)
  );

  assign set_vec[F_OVF]   = ovf_evt;
  assign set_vec[F_MATCH] = match_evt;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    tmr_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n_i),
      .set_evt (set_vec[i]),
      .sts_rd  (rd_sts),
      .sts_wr  (wr_sts),
      .wr_bit  (reg_wdata[i]),
      .flag    (flags[i])
    );
  end

  assign ovf_flag   = flags[F_OVF];
  assign match_flag = flags[F_MATCH];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:   reg_rdata[CTRL_W-1:0] = {sel_q, run_q};
      A_COUNT:  reg_rdata = count;
      A_PERIOD: reg_rdata = per_q;
      default:  reg_rdata[NFLAG-1:0] = flags;
    endcase
  end

  // R6: other clear codes never force a clear at the period value
  p_free_no_clear_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (run_q && tick && !wr_cnt && sel_q != SEL_MATCH && count == per_q && per_q != {CNT_W{1'b1}})
    |=> (count == $past(count) + 1'b1));

  // R9: wrap at a 0xFFFF period raises both flags together
  p_both_flags_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (run_q && tick && !wr_cnt && sel_q == SEL_MATCH && per_q == {CNT_W{1'b1}} && count == per_q)
    |=> (ovf_flag && match_flag));
endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        ovf_flag, match_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_channel u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ovf_flag(ovf_flag), .match_flag(match_flag)
  );

  typedef struct packed {
    logic [15:0] per;
    logic [2:0]  mode;
    logic [7:0]  n;
    logic [15:0] cnt;
    logic [1:0]  st;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{16'hFFFF, 3'd0, 8'd5,  16'd5,  2'b00},  // R2
    '{16'd3,    3'd1, 8'd4,  16'd0,  2'b10},  // R5
    '{16'd3,    3'd1, 8'd6,  16'd2,  2'b10},  // R5
    '{16'd3,    3'd0, 8'd6,  16'd6,  2'b10},  // R6
    '{16'd2,    3'd5, 8'd5,  16'd5,  2'b10},  // R6
    '{16'd0,    3'd1, 8'd3,  16'd0,  2'b10},  // R5
    '{16'd100,  3'd0, 8'd10, 16'd10, 2'b00}   // R2
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d, input logic tk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; tick = tk;
    @(negedge clk);
    reg_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic clear_flags();
    logic [15:0] s;
    bus_read(2'd3, s);
    bus_write(2'd3, 16'h0000, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; tick = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_addr = 2'd0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    peek(2'd0, v); check("R1 ctrl",   v, 16'h0000);
    peek(2'd1, v); check("R1 count",  v, 16'h0000);
    peek(2'd2, v); check("R1 period", v, 16'hFFFF);
    peek(2'd3, v); check("R1 status", v, 16'h0000);

    // vector table
    for (int i = 0; i < NV; i++) begin
      bus_write(2'd0, 16'h0000, 1'b0);
      bus_write(2'd1, 16'h0000, 1'b0);
      clear_flags();
      bus_write(2'd2, VEC[i].per, 1'b0);
      bus_write(2'd0, {12'd0, VEC[i].mode, 1'b1}, 1'b0);
      ticks(VEC[i].n);
      bus_write(2'd0, 16'h0000, 1'b0);
      peek(2'd1, v); check($sformatf("R2/R5/R6 vec%0d count", i), v, VEC[i].cnt);
      peek(2'd3, v); check($sformatf("R5/R6 vec%0d status", i), v, {14'd0, VEC[i].st});
    end
    clear_flags();

    // R2: running but tick low
    bus_write(2'd1, 16'd7, 1'b0);
    bus_write(2'd0, 16'h0001, 1'b0);
    repeat (4) @(negedge clk);
    peek(2'd1, v); check("R2 no tick", v, 16'd7);

    // R3: stop holds, restart resumes
    ticks(3);
    bus_write(2'd0, 16'h0000, 1'b0);
    ticks(5);
    peek(2'd1, v); check("R3 hold", v, 16'd10);
    bus_write(2'd0, 16'h0001, 1'b0);
    ticks(2);
    peek(2'd1, v); check("R3 resume", v, 16'd12);

    // R4: overflow in free mode
    bus_write(2'd0, 16'h0000, 1'b0);
    bus_write(2'd2, 16'h1234, 1'b0);
    bus_write(2'd1, 16'hFFFE, 1'b0);
    bus_write(2'd0, 16'h0001, 1'b0);
    ticks(3);
    peek(2'd1, v); check("R4 count", v, 16'h0001);
    peek(2'd3, v); check("R4 status", v, 16'h0001);

    // R7: unarmed clear ignored, write one ignored, armed clear works
    bus_write(2'd3, 16'h0000, 1'b0);
    peek(2'd3, v); check("R7 unarmed", v, 16'h0001);
    bus_read(2'd3, v);
    bus_write(2'd3, 16'h0001, 1'b0);
    peek(2'd3, v); check("R7 write one", v, 16'h0001);
    bus_write(2'd3, 16'h0000, 1'b0);
    peek(2'd3, v); check("R7 cleared", v, 16'h0000);

    // R9: period 0xFFFF in match mode
    bus_write(2'd0, 16'h0000, 1'b0);
    bus_write(2'd2, 16'hFFFF, 1'b0);
    bus_write(2'd1, 16'hFFFE, 1'b0);
    bus_write(2'd0, 16'h0003, 1'b0);
    ticks(2);
    peek(2'd1, v); check("R9 count", v, 16'h0000);
    peek(2'd3, v); check("R9 status", v, 16'h0003);
    clear_flags();

    // R8: set event and armed clear on same clock
    bus_write(2'd0, 16'h0000, 1'b0);
    bus_write(2'd2, 16'd5, 1'b0);
    bus_write(2'd1, 16'd5, 1'b0);
    bus_write(2'd0, 16'h0003, 1'b0);
    ticks(1);
    bus_read(2'd3, v);
    check("R8 pre", v, 16'h0002);
    bus_write(2'd1, 16'd5, 1'b0);
    reg_addr = 2'd3;
    bus_write(2'd3, 16'h0000, 1'b1);
    peek(2'd3, v); check("R8 set wins", v, 16'h0002);
    clear_flags();
    peek(2'd3, v); check("R7 re-armed clear", v, 16'h0000);

    // R10: counter write beats compare clear and increment
    bus_write(2'd1, 16'd5, 1'b0);
    bus_write(2'd1, 16'h0100, 1'b1);
    peek(2'd1, v); check("R10 count", v, 16'h0100);
    peek(2'd3, v); check("R10 no event", v, 16'h0000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule